// File: doc/BRIEF.md
# Sample Readout Interface

This block holds one set of 16-bit conversion results for up to eight channels and hands them to a host processor. It offers three interface modes, which two static mode pins choose. In word mode the whole result appears on a 16-bit bus. In byte mode each result is split into two bytes on the low eight lanes of the bus. In serial mode two data lines each shift out half of the channels, MSB first, on a host-supplied serial clock. A single host strobe serves as the read strobe in the two bus modes and as the serial clock in serial mode.

All host pins are sampled on the system clock. The host strobes are assumed to be synchronous to that clock, or already synchronised. A one-cycle latch strobe from the conversion sequencer captures a fresh result set and rewinds every read position to channel 1. A first-channel indicator, with its own output enable, tells the host when channel 1 is being delivered. Three-state pins are modelled as a value plus an output-enable signal.

Top module: `sample_readout`

## Requirements
- R1: The mode pins decode as follows. `sel_serial`=0 selects word mode. `sel_serial`=1 with `sel_byte`=0 selects serial mode. `sel_serial`=1 with `sel_byte`=1 selects byte mode. In serial mode `bus_oe` stays 0.
- R2: In word and byte mode, `bus_oe` is 1 in the cycle after `cs_n` and `rd_sclk` are both sampled low, and 0 in the cycle after either is sampled high. `bus_oe` and `sdo_oe` are never 1 together.
- R3: In word mode, each falling edge of `rd_sclk` while `cs_n` is low places the next channel's full result on `bus_data`, one cycle after the edge is sampled. The first read after a latch gives channel 1, and the read after channel 8 wraps to channel 1.
- R4: In byte mode, each channel takes two reads. The byte appears on `bus_data[7:0]` and `bus_data[15:8]` is zero. With `hben`=1 the high byte comes first; with `hben`=0 the low byte comes first.
- R5: In serial mode, a falling edge of `cs_n` sets `sdo_oe` to 1 one cycle later. At that point `sdo_a` holds bit 15 of channel 1 and `sdo_b` holds bit 15 of channel 5.
- R6: In serial mode, each rising edge of `rd_sclk` while `cs_n` is low advances both lines by one bit. Line A sends channels 1 to 4 and line B sends channels 5 to 8, each channel MSB first, 64 bits per line. Without such an edge or a latch strobe, both lines hold their value.
- R7: `first_oe` is 1 in the cycle after `cs_n` is sampled low and 0 in the cycle after it is sampled high.
- R8: In word and byte mode, `first_ch` goes to 1 on the read falling edge that delivers channel 1 (its first byte in byte mode). It goes to 0 on the next read falling edge. A falling edge of `cs_n` alone clears it.
- R9: In serial mode, a falling edge of `cs_n` sets `first_ch` to 1 when the lines are at the start of channel 1, and to 0 otherwise. `first_ch` returns to 0 on the 16th falling edge of `rd_sclk` after the `cs_n` fall.
- R10: A pulse on `latch_stb` stores `results` and rewinds word, byte and serial positions to channel 1. Changes on `results` without the strobe do not change what is read.
- R11: After reset, `bus_oe`, `sdo_oe`, `first_oe`, `first_ch` and `bus_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_serial | input | 1 | Mode pin: 0 word, 1 serial or byte |
| sel_byte | input | 1 | Mode pin: with sel_serial=1, 1 selects byte mode |
| hben | input | 1 | Byte order in byte mode: 1 high byte first |
| cs_n | input | 1 | Active-low chip select from host |
| rd_sclk | input | 1 | Read strobe (bus modes) or serial clock (serial mode) |
| latch_stb | input | 1 | One-cycle strobe that captures a new result set |
| results | input | NCH*DW | Packed results, channel 1 in the low word |
| bus_data | output | DW | Parallel data value |
| bus_oe | output | 1 | Parallel bus drive enable |
| sdo_a | output | 1 | Serial line A (channels 1 to 4) |
| sdo_b | output | 1 | Serial line B (channels 5 to 8) |
| sdo_oe | output | 1 | Serial lines drive enable |
| first_ch | output | 1 | First-channel indicator |
| first_oe | output | 1 | Drive enable of the indicator |

## Verification
A channel pointer or byte phase that drifts shows on the very next read as the wrong word or the wrong byte half. A stray indicator pulse appears in that same cycle, because the indicator is recomputed on every read edge. A serial shift register out of step shows within one serial clock as a wrong bit on one of the lines. A faulty indicator falling-edge count appears as the indicator dropping before or after the 16th clock. A pointer that a latch fails to rewind is caught on the first read after the latch, which returns a channel other than 1.

// File: rtl/readout_pkg.sv
package readout_pkg;

    // Interface mode chosen by the static mode pins.
    typedef enum logic [1:0] {
        RM_WORD   = 2'd0,
        RM_SERIAL = 2'd1,
        RM_BYTE   = 2'd2
    } rd_mode_e;

    // Decodes the two mode pins into an interface mode.
    function automatic rd_mode_e decode_mode(input logic ser, input logic byt);
        if (!ser)
            return RM_WORD;
        else if (byt)
            return RM_BYTE;
        else
            return RM_SERIAL;
    endfunction

endpackage

// File: rtl/rdo_strobe_edges.sv
// Edge detector for the host strobes.
// Assumes cs_n and rd_n are synchronous to clk. Read edges count only
// while chip select is low.
module rdo_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    output logic cs_fall,
    output logic rd_fall,
    output logic rd_rise
);
    logic cs_q;
    logic rd_q;

    // Keep the previous level of each strobe; both idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
            rd_q <= rd_n;
        end
    end

    assign cs_fall = cs_q & ~cs_n;
    assign rd_fall = rd_q & ~rd_n & ~cs_n;
    assign rd_rise = ~rd_q & rd_n & ~cs_n;
endmodule

// File: rtl/rdo_result_bank.sv
// Result register file: one register per channel, loaded together on load.
// Assumes load is a single-cycle strobe from the conversion sequencer.
module rdo_result_bank #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCH*DW-1:0] din,
    output logic [NCH*DW-1:0] words
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Capture this channel's result on the latch strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[c*DW +: DW] <= '0;
            else if (load)
                words[c*DW +: DW] <= din[c*DW +: DW];
        end
    end
endmodule

// File: rtl/rdo_word_port.sv
// Word and byte read path: channel pointer, byte phase and bus data register.
// Assumes rd_fall already means a read edge while chip select is low.
// A restart takes priority over a read in the same cycle.
module rdo_word_port #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_mode,
    input  logic              hben,
    input  logic              restart,
    input  logic              rd_fall,
    input  logic [NCH*DW-1:0] words,
    output logic [DW-1:0]     data,
    output logic              first_word
);
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int HB = DW / 2;

    logic [PW-1:0] ptr;
    logic          phase;
    logic [DW-1:0] cur;
    logic [PW-1:0] ptr_next;
    logic          hi_sel;

    // Select the word the pointer addresses.
    always_comb begin
        cur = words[DW-1:0];
        for (int c = 0; c < NCH; c++)
            if (ptr == PW'(c))
                cur = words[c*DW +: DW];
    end

    assign ptr_next   = (ptr == PW'(NCH - 1)) ? '0 : ptr + 1'b1;
    assign hi_sel     = phase ? ~hben : hben;
    assign first_word = (ptr == '0) && !phase;

    // Advance pointer and phase, and present the addressed word or byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            phase <= 1'b0;
            data  <= '0;
        end else if (restart) begin
            ptr   <= '0;
            phase <= 1'b0;
        end else if (enable && rd_fall) begin
            if (byte_mode) begin
                data  <= hi_sel ? {{(DW-HB){1'b0}}, cur[DW-1:HB]}
                                : {{(DW-HB){1'b0}}, cur[HB-1:0]};
                phase <= ~phase;
                if (phase)
                    ptr <= ptr_next;
            end else begin
                data <= cur;
                ptr  <= ptr_next;
            end
        end
    end
endmodule

// File: rtl/rdo_serial_lanes.sv
// Serial shifters: one shift register per line, each holding NCH/LANES channels.
// The lowest channel of a line sits at the MSB end. Loaded on the latch
// strobe, shifted left by one on each shift pulse, zero-filled.
module rdo_serial_lanes #(
    parameter int NCH   = 8,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [NCH*DW-1:0] din,
    output logic [LANES-1:0]  sdo,
    output logic              at_start
);
    localparam int CPL = NCH / LANES;
    localparam int LW  = CPL * DW;
    localparam int SBW = $clog2(LW + 1);

    logic [SBW-1:0] sbit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] sr;
        logic [LW-1:0] img;

        // Arrange this line's channels, first channel at the MSB end.
        always_comb begin
            img = '0;
            for (int c = 0; c < CPL; c++)
                img[LW-1-c*DW -: DW] = din[(l*CPL+c)*DW +: DW];
        end

        // Load on latch; otherwise shift one bit per pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sr <= '0;
            else if (load)
                sr <= img;
            else if (shift)
                sr <= {sr[LW-2:0], 1'b0};
        end

        assign sdo[l] = sr[LW-1];
    end

    // Count bits shifted since the last load, saturating at the line length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sbit <= '0;
        else if (load)
            sbit <= '0;
        else if (shift && sbit != SBW'(LW))
            sbit <= sbit + 1'b1;
    end

    assign at_start = (sbit == '0);
endmodule

// File: rtl/sample_readout.sv
// Top module of the sample readout interface.
// Serves latched results in word, byte or serial mode, and drives the
// first-channel indicator and all output enables. Assumes the mode pins
// change only while cs_n is high, and that host strobes are synchronous to clk.
module sample_readout #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_serial,
    input  logic              sel_byte,
    input  logic              hben,
    input  logic              cs_n,
    input  logic              rd_sclk,
    input  logic              latch_stb,
    input  logic [NCH*DW-1:0] results,
    output logic [DW-1:0]     bus_data,
    output logic              bus_oe,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              sdo_oe,
    output logic              first_ch,
    output logic              first_oe
);
    import readout_pkg::*;

    localparam int LANES = 2;
    localparam int CW    = $clog2(DW + 1);

    rd_mode_e         mode;
    logic             ser;
    logic             cs_fall;
    logic             rd_fall;
    logic             rd_rise;
    logic             first_word;
    logic             at_start;
    logic [LANES-1:0] sdo;
    logic [NCH*DW-1:0] words;
    logic [CW-1:0]    fall_cnt;

    assign mode = decode_mode(sel_serial, sel_byte);
    assign ser  = (mode == RM_SERIAL);

    rdo_strobe_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_sclk),
        .cs_fall (cs_fall),
        .rd_fall (rd_fall),
        .rd_rise (rd_rise)
    );

    rdo_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_stb),
        .din   (results),
        .words (words)
    );

    rdo_word_port #(.NCH(NCH), .DW(DW)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (!ser),
        .byte_mode  (mode == RM_BYTE),
        .hben       (hben),
        .restart    (latch_stb),
        .rd_fall    (rd_fall),
        .words      (words),
        .data       (bus_data),
        .first_word (first_word)
    );

    rdo_serial_lanes #(.NCH(NCH), .DW(DW), .LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (latch_stb),
        .shift    (ser && rd_rise),
        .din      (results),
        .sdo      (sdo),
        .at_start (at_start)
    );

    assign sdo_a = sdo[0];
    assign sdo_b = sdo[1];

    // Register the drive enables from the sampled chip select and read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_oe   <= 1'b0;
            sdo_oe   <= 1'b0;
            first_oe <= 1'b0;
        end else begin
            bus_oe   <= !ser && !cs_n && !rd_sclk;
            sdo_oe   <= ser && !cs_n;
            first_oe <= !cs_n;
        end
    end

    // First-channel indicator: per-mode set and clear edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_ch <= 1'b0;
            fall_cnt <= '0;
        end else begin
            if (cs_fall) begin
                fall_cnt <= '0;
                first_ch <= ser ? at_start : 1'b0;
            end
            if (ser) begin
                if (rd_fall && !cs_fall) begin
                    if (fall_cnt == CW'(DW - 1))
                        first_ch <= 1'b0;
                    if (fall_cnt != CW'(DW))
                        fall_cnt <= fall_cnt + 1'b1;
                end
            end else if (rd_fall) begin
                first_ch <= first_word;
            end
        end
    end
endmodule

// File: rtl/sample_readout_chk.sv
// Checker for sample_readout: enable exclusivity, drive timing,
// byte lane content and serial line hold.
module sample_readout_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_serial,
    input logic          sel_byte,
    input logic          cs_n,
    input logic          rd_sclk,
    input logic          latch_stb,
    input logic [DW-1:0] bus_data,
    input logic          bus_oe,
    input logic          sdo_a,
    input logic          sdo_b,
    input logic          sdo_oe
    ,input logic         first_oe
);
    // R2: the bus and the serial lines are never driven together.
    p_oe_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && sdo_oe));

    // R2: a high chip select or read strobe turns the bus off next cycle.
    p_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) || $past(rd_sclk)) |-> !bus_oe);

    // R7: the indicator is undriven after chip select was high.
    p_flag_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !first_oe);

    // R4: in byte mode the upper lanes carry zero.
    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && sel_serial && sel_byte && $past(sel_serial && sel_byte))
        |-> (bus_data[DW-1:DW/2] == '0));

    // R6: serial lines hold unless a serial clock rise or latch occurred.
    p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_stb && !(rd_sclk && !$past(rd_sclk) && !cs_n))
        |=> ($stable(sdo_a) && $stable(sdo_b)));
endmodule

bind sample_readout sample_readout_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_serial (sel_serial),
    .sel_byte   (sel_byte),
    .cs_n       (cs_n),
    .rd_sclk    (rd_sclk),
    .latch_stb  (latch_stb),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe),
    .sdo_a      (sdo_a),
    .sdo_b      (sdo_b),
    .sdo_oe     (sdo_oe),
    .first_oe   (first_oe)
);

// File: tb/tb_sample_readout.sv
module tb_sample_readout;
    localparam int NCH = 8;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_serial = 1'b0;
    logic              sel_byte = 1'b0;
    logic              hben = 1'b0;
    logic              cs_n = 1'b1;
    logic              rd_sclk = 1'b1;
    logic              latch_stb = 1'b0;
    logic [NCH*DW-1:0] results = '0;
    logic [DW-1:0]     bus_data;
    logic              bus_oe;
    logic              sdo_a;
    logic              sdo_b;
    logic              sdo_oe;
    logic              first_ch;
    logic              first_oe;

    int n_chk = 0;
    int n_bad = 0;
    int gen   = 0;
    bit done  = 1'b0;

    sample_readout #(.NCH(NCH), .DW(DW)) dut (.*);

    always #10 clk = ~clk;

    // Read vector: latch first, mode (0 word, 2 byte), hben, channel,
    // part (0 word, 1 high byte, 2 low byte), expected indicator.
    typedef struct packed {
        logic       ld;
        logic [1:0] md;
        logic       hb;
        logic [3:0] ch;
        logic [1:0] pt;
        logic       fl;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1},
        '{1'b0, 2'd0, 1'b0, 4'd1, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd2, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd3, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd4, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd6, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd7, 2'd0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1},
        '{1'b0, 2'd0, 1'b0, 4'd1, 2'd0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'd0, 2'd0, 1'b1},
        '{1'b1, 2'd2, 1'b1, 4'd0, 2'd1, 1'b1},
        '{1'b0, 2'd2, 1'b1, 4'd0, 2'd2, 1'b0},
        '{1'b0, 2'd2, 1'b1, 4'd1, 2'd1, 1'b0},
        '{1'b0, 2'd2, 1'b1, 4'd1, 2'd2, 1'b0},
        '{1'b1, 2'd2, 1'b0, 4'd0, 2'd2, 1'b1},
        '{1'b0, 2'd2, 1'b0, 4'd0, 2'd1, 1'b0},
        '{1'b0, 2'd2, 1'b0, 4'd1, 2'd2, 1'b0},
        '{1'b0, 2'd2, 1'b0, 4'd1, 2'd1, 1'b0}
    };

    function automatic logic [DW-1:0] pat(int g, int k);
        return DW'(((g + 1) * 32'h1357) ^ ((k + 1) * 32'h0A1B) ^ 32'h8001);
    endfunction

    function automatic logic [NCH*DW-1:0] pack(int g);
        logic [NCH*DW-1:0] r;
        for (int k = 0; k < NCH; k++)
            r[k*DW +: DW] = pat(g, k);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Latch pattern gen+1, then put unrelated data on the inputs (R10).
    task automatic do_latch();
        gen++;
        @(negedge clk);
        results   = pack(gen);
        latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
        results   = pack(gen + 100);
    endtask

    task automatic set_mode(int m);
        sel_serial = (m != 0);
        sel_byte   = (m == 2);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w;
        logic [DW-1:0] expd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 bus_oe", 32'(bus_oe), 0);
        check("R11 sdo_oe", 32'(sdo_oe), 0);
        check("R11 first_oe", 32'(first_oe), 0);
        check("R11 first_ch", 32'(first_ch), 0);
        check("R11 bus_data", 32'(bus_data), 0);

        // Table walk: word mode (R3, R10) and byte mode (R4), indicator R8
        for (int v = 0; v < NV; v++) begin
            set_mode(int'(VEC[v].md));
            hben = VEC[v].hb;
            if (VEC[v].ld) do_latch();
            @(negedge clk);
            cs_n = 1'b0;
            rd_sclk = 1'b0;
            @(negedge clk);
            w = pat(gen, int'(VEC[v].ch));
            case (VEC[v].pt)
                2'd1:    expd = {8'h00, w[15:8]};
                2'd2:    expd = {8'h00, w[7:0]};
                default: expd = w;
            endcase
            check("R1/R2 bus_oe on", 32'(bus_oe), 1);
            check(VEC[v].md == 2'd2 ? "R4 byte data" : "R3/R10 word data",
                  32'(bus_data), 32'(expd));
            check("R8 first_ch", 32'(first_ch), 32'(VEC[v].fl));
            check("R7 first_oe on", 32'(first_oe), 1);
            cs_n = 1'b1;
            rd_sclk = 1'b1;
            @(negedge clk);
            check("R2 bus_oe off", 32'(bus_oe), 0);
            check("R7 first_oe off", 32'(first_oe), 0);
        end

        // R8: chip select falling alone clears the indicator
        set_mode(0);
        do_latch();
        @(negedge clk); cs_n = 1'b0; rd_sclk = 1'b0;
        @(negedge clk); check("R8 set by ch1 read", 32'(first_ch), 1);
        rd_sclk = 1'b1; cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); check("R8 cleared by cs fall", 32'(first_ch), 0);
        check("R2 bus off with rd high", 32'(bus_oe), 0);
        cs_n = 1'b1;
        @(negedge clk);

        // Serial mode: R1, R5, R6, R9
        set_mode(1);
        do_latch();
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R5 sdo_oe", 32'(sdo_oe), 1);
        check("R1 no bus in serial", 32'(bus_oe), 0);
        check("R9 first_ch at cs fall", 32'(first_ch), 1);
        for (int i = 0; i < 64; i++) begin
            check(i == 0 ? "R5 sdo_a msb" : "R6 sdo_a",
                  32'(sdo_a), 32'(pat(gen, i / 16)[15 - i % 16]));
            check(i == 0 ? "R5 sdo_b msb" : "R6 sdo_b",
                  32'(sdo_b), 32'(pat(gen, 4 + i / 16)[15 - i % 16]));
            rd_sclk = 1'b0;
            @(negedge clk);
            check("R9 first_ch after fall", 32'(first_ch), (i < 15) ? 1 : 0);
            check("R1 bus stays off", 32'(bus_oe), 0);
            rd_sclk = 1'b1;
            @(negedge clk);
        end
        check("R6 line empty", 32'(sdo_a), 0);
        cs_n = 1'b1;
        @(negedge clk);
        check("R5 sdo_oe off", 32'(sdo_oe), 0);
        check("R7 first_oe off serial", 32'(first_oe), 0);
        cs_n = 1'b0;
        @(negedge clk);
        check("R9 no flag mid-stream", 32'(first_ch), 0);
        cs_n = 1'b1;
        do_latch();
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R10 serial rewind flag", 32'(first_ch), 1);
        check("R10 serial rewind data", 32'(sdo_a), 32'(pat(gen, 0)[15]));
        cs_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule